// File: doc/BRIEF.md
# Double to Int32 Modulo Converter

This block takes a 64-bit IEEE-754 double-precision operand and turns it into a 32-bit signed integer. Any fraction is dropped, so rounding is always toward zero. Some values have an integer part that does not fit in 32 signed bits. For these the block does not clamp. It keeps the low 32 bits of the two's-complement integer, which carries the operand's sign.

Next to the result the block gives a four-bit flag nibble. Only the Z bit in that nibble is ever set. Z tells software whether the operand was exactly a signed 32-bit integer, so a conditional branch can follow the conversion directly. Special operands always give a result of zero: NaN, infinity, subnormals and negative zero.

Operands arrive with a valid strobe. The result, the flags and an output valid come from registers one clock later. When no operand is offered, the output registers keep their last result.

Top module: `dbl_to_i32_wrap`

## Requirements
- R1: A finite operand whose truncated integer lies in [-2^31, 2^31-1] yields that integer, with the fraction discarded toward zero (3.7 gives 3, -3.7 gives -3).
- R2: When the truncated integer magnitude M lies outside the signed 32-bit range, the result is the low 32 bits of -M for a negative operand and of M for a positive one (2^31 gives 0x80000000, 2^32+5 gives 5, -(2^31+1) gives 0x7FFFFFFF).
- R3: Z is 1 only when the operand is an integer in [-2^31, 2^31-1], including both ends of that range. Otherwise Z is 0.
- R4: If any nonzero fraction bit is discarded, Z is 0 (0.5 gives result 0 with Z 0).
- R5: NaN and infinity operands (exponent field all ones) give result 0 with Z 0.
- R6: Positive zero gives result 0 with Z 1. Negative zero (only the sign bit set) gives result 0 with Z 0.
- R7: Subnormal operands (exponent field zero, mantissa nonzero) give result 0 with Z 0.
- R8: An unbiased exponent of 84 or more (exponent field from 1107 up to, but not including, all ones) gives result 0 with Z 0.
- R9: The flag nibble is ordered N (bit 3), Z (bit 2), C (bit 1), V (bit 0). N, C and V are always 0.
- R10: `out_vld` equals `in_vld` from the previous clock. The result and flags for an operand appear in that same cycle, so back-to-back operands stream at one per clock.
- R11: In a cycle where `in_vld` is low, `out_res` and `out_nzcv` keep their values at the next clock edge.
- R12: A synchronous active-high `rst` clears `out_vld`, `out_res` and `out_nzcv` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand strobe |
| in_op | input | 64 | Double-precision operand: sign bit 63, exponent 62:52, mantissa 51:0 |
| out_vld | output | 1 | Registered result valid |
| out_res | output | 32 | Registered converted integer |
| out_nzcv | output | 4 | Registered flags {N, Z, C, V} |

## Verification

The bench aims at the edges of the signed range: 2^31-1, -2^31, 2^31 and -(2^31+1). An off-by-one range test would wrongly set or clear Z at these values, and a saturating design would return 0x7FFFFFFF instead of wrapping.

It also targets the following cases:
- Pure fractions such as 0.5. A design that left out the fraction mask would report them as exact.
- Signed zeros. A design that ignored the sign would set Z for -0.
- Subnormals, NaN and infinity. A decoder that treated the exponent field numerically would produce garbage for these.
- The shift seam at exponents 52, 83 and 84, where a wrong left-shift bound drops or invents bit 31.

Seeded random operands around the interesting exponents cover everything between these points. Idle cycles with a changing operand check that the outputs do not move.

// File: rtl/dcvt_pkg.sv
`timescale 1ns/1ps
package dcvt_pkg;

    // operand class from the exponent and mantissa fields
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_NAN  = 3'd4
    } dcvt_cls_e;

    // flag nibble layout
    localparam int NZCV_W = 4;
    localparam int FLG_N  = 3;
    localparam int FLG_Z  = 2;
    localparam int FLG_C  = 1;
    localparam int FLG_V  = 0;

endpackage

// File: rtl/dcvt_classify.sv
`timescale 1ns/1ps
module dcvt_classify
    import dcvt_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    localparam int OP_W  = 1 + EXP_W + MAN_W,
    localparam int SIG_W = MAN_W + 1,
    localparam int UE_W  = EXP_W + 2
) (
    input  logic                   op_i_sign,
    input  logic [EXP_W-1:0]       op_i_exp,
    input  logic [MAN_W-1:0]       op_i_man,
    output dcvt_cls_e              cls_o,
    output logic signed [UE_W-1:0] uexp_o,
    output logic [SIG_W-1:0]       sig_o,
    output logic                   neg_o
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic exp_zero;
    logic exp_ones;
    logic man_zero;

    assign exp_zero = (op_i_exp == '0);
    assign exp_ones = (op_i_exp == '1);
    assign man_zero = (op_i_man == '0);

    always_comb begin
        if (exp_zero) begin
            cls_o = man_zero ? CLS_ZERO : CLS_SUB;
        end else if (exp_ones) begin
            cls_o = man_zero ? CLS_INF : CLS_NAN;
        end else begin
            cls_o = CLS_NORM;
        end
    end

    // unbiased exponent, signed so that pure fractions show as negative
    assign uexp_o = $signed({2'b00, op_i_exp}) - $signed(UE_W'(BIAS));

    // significand with the hidden bit restored for normal operands
    assign sig_o  = {~exp_zero, op_i_man};
    assign neg_o  = op_i_sign;

endmodule

// File: rtl/dcvt_trunc.sv
`timescale 1ns/1ps
module dcvt_trunc
    import dcvt_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    parameter  int INT_W = 32,
    localparam int SIG_W = MAN_W + 1,
    localparam int UE_W  = EXP_W + 2
) (
    input  dcvt_cls_e              cls_i,
    input  logic signed [UE_W-1:0] uexp_i,
    input  logic [SIG_W-1:0]       sig_i,
    output logic [INT_W-1:0]       mag_o,
    output logic                   inexact_o
);

    // beyond this exponent no significand bit reaches the low INT_W bits
    localparam int LIM  = MAN_W + INT_W;
    localparam int SH_W = $clog2(SIG_W + INT_W) + 1;

    logic [SH_W-1:0]  rsh;
    logic [SH_W-1:0]  lsh;
    logic [SIG_W-1:0] frac_mask;
    logic [SIG_W-1:0] sig_rs;

    always_comb begin
        mag_o     = '0;
        inexact_o = 1'b0;
        rsh       = '0;
        lsh       = '0;
        frac_mask = '0;
        sig_rs    = '0;
        if (cls_i == CLS_NORM) begin
            if (uexp_i < 0) begin
                // magnitude below one: all bits are fraction
                inexact_o = 1'b1;
            end else if (uexp_i <= MAN_W) begin
                // binary point inside the significand
                rsh       = SH_W'(MAN_W) - SH_W'(uexp_i);
                sig_rs    = sig_i >> rsh;
                mag_o     = INT_W'(sig_rs);
                frac_mask = {SIG_W{1'b1}} >> (SH_W'(SIG_W) - rsh);
                inexact_o = |(sig_i & frac_mask);
            end else if (uexp_i < LIM) begin
                // integer larger than the significand: shift left, keep low bits
                lsh       = SH_W'(uexp_i) - SH_W'(MAN_W);
                mag_o     = INT_W'(sig_i) << lsh;
            end
        end
    end

endmodule

// File: rtl/dcvt_pack.sv
`timescale 1ns/1ps
module dcvt_pack
    import dcvt_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    parameter  int INT_W = 32,
    localparam int SIG_W = MAN_W + 1,
    localparam int UE_W  = EXP_W + 2
) (
    input  logic                   neg_i,
    input  dcvt_cls_e              cls_i,
    input  logic signed [UE_W-1:0] uexp_i,
    input  logic [SIG_W-1:0]       sig_i,
    input  logic [INT_W-1:0]       mag_i,
    input  logic                   inexact_i,
    output logic [INT_W-1:0]       res_o,
    output logic                   zflag_o
);

    logic pos_fit;
    logic neg_edge;
    logic in_range;

    // range decided from the exponent: below 2^(INT_W-1) always fits,
    // exactly 2^(INT_W-1) fits only for a negative operand
    assign pos_fit  = (uexp_i <= (INT_W - 2));
    assign neg_edge = neg_i && (uexp_i == (INT_W - 1)) &&
                      (sig_i == (SIG_W'(1) << MAN_W));
    assign in_range = pos_fit || neg_edge;

    always_comb begin
        res_o   = '0;
        zflag_o = 1'b0;
        unique case (cls_i)
            CLS_NORM: begin
                res_o   = neg_i ? (~mag_i + INT_W'(1)) : mag_i;
                zflag_o = in_range && !inexact_i;
            end
            CLS_ZERO: begin
                zflag_o = !neg_i;
            end
            default: begin
                res_o   = '0;
                zflag_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dbl_to_i32_wrap.sv
`timescale 1ns/1ps
module dbl_to_i32_wrap
    import dcvt_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    parameter  int INT_W = 32,
    localparam int OP_W  = 1 + EXP_W + MAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [OP_W-1:0]   in_op,
    output logic              out_vld,
    output logic [INT_W-1:0]  out_res,
    output logic [NZCV_W-1:0] out_nzcv
);

    localparam int SIG_W = MAN_W + 1;
    localparam int UE_W  = EXP_W + 2;

    typedef struct packed {
        logic              vld;
        logic [INT_W-1:0]  res;
        logic [NZCV_W-1:0] nzcv;
    } out_st_t;

    out_st_t st_d;
    out_st_t st_q;

    dcvt_cls_e              cls;
    logic signed [UE_W-1:0] uexp;
    logic [SIG_W-1:0]       sig;
    logic                   neg;
    logic [INT_W-1:0]       mag;
    logic                   inexact;
    logic [INT_W-1:0]       cv_res;
    logic                   cv_z;

    dcvt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
        .op_i_sign (in_op[OP_W-1]),
        .op_i_exp  (in_op[OP_W-2:MAN_W]),
        .op_i_man  (in_op[MAN_W-1:0]),
        .cls_o     (cls),
        .uexp_o    (uexp),
        .sig_o     (sig),
        .neg_o     (neg)
    );

    dcvt_trunc #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_trunc (
        .cls_i     (cls),
        .uexp_i    (uexp),
        .sig_i     (sig),
        .mag_o     (mag),
        .inexact_o (inexact)
    );

    dcvt_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_pack (
        .neg_i     (neg),
        .cls_i     (cls),
        .uexp_i    (uexp),
        .sig_i     (sig),
        .mag_i     (mag),
        .inexact_i (inexact),
        .res_o     (cv_res),
        .zflag_o   (cv_z)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.res         = cv_res;
            st_d.nzcv        = '0;
            st_d.nzcv[FLG_Z] = cv_z;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_res  = st_q.res;
    assign out_nzcv = st_q.nzcv;

endmodule

// File: rtl/dcvt_chk.sv
`timescale 1ns/1ps
module dcvt_chk
    import dcvt_pkg::*;
#(
    parameter  int EXP_W = 11,
    parameter  int MAN_W = 52,
    parameter  int INT_W = 32,
    localparam int OP_W  = 1 + EXP_W + MAN_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [OP_W-1:0]   in_op,
    input logic              out_vld,
    input logic [INT_W-1:0]  out_res,
    input logic [NZCV_W-1:0] out_nzcv
);

    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int BIG_EF = BIAS + MAN_W + INT_W;

    logic [EXP_W-1:0] ef;
    logic [MAN_W-1:0] mf;
    assign ef = in_op[OP_W-2:MAN_W];
    assign mf = in_op[MAN_W-1:0];

    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R10
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_res) && $stable(out_nzcv)));
    // R9
    ncv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_nzcv[FLG_N] && !out_nzcv[FLG_C] && !out_nzcv[FLG_V]));
    // R5
    nan_inf_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ef == '1) |=> (out_res == '0 && !out_nzcv[FLG_Z]));
    // R6
    neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == {1'b1, {(OP_W-1){1'b0}}}) |=> (out_res == '0 && !out_nzcv[FLG_Z]));
    // R6
    pos_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == '0) |=> (out_res == '0 && out_nzcv[FLG_Z]));
    // R7
    subnormal_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ef == '0 && mf != '0) |=> (out_res == '0 && !out_nzcv[FLG_Z]));
    // R8
    huge_exp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && ef >= EXP_W'(BIG_EF) && ef != '1) |=> (out_res == '0 && !out_nzcv[FLG_Z]));
    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && out_res == '0 && out_nzcv == '0));

endmodule

bind dbl_to_i32_wrap dcvt_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_op    (in_op),
    .out_vld  (out_vld),
    .out_res  (out_res),
    .out_nzcv (out_nzcv)
);

// File: tb/tb_dbl_to_i32_wrap.sv
`timescale 1ns/1ps
module tb_dbl_to_i32_wrap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [63:0] in_op = '0;
    logic        out_vld;
    logic [31:0] out_res;
    logic [3:0]  out_nzcv;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dbl_to_i32_wrap dut (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_op    (in_op),
        .out_vld  (out_vld),
        .out_res  (out_res),
        .out_nzcv (out_nzcv)
    );

    // expected conversion from the requirements: exact wide integer, then wrap
    function automatic void ref_conv(input logic [63:0] op,
                                     output logic [31:0] r, output logic z);
        logic        s;
        logic [10:0] e;
        logic [51:0] f;
        int          ue;
        logic [191:0] big;
        logic [139:0] ip;
        logic        inr;
        s = op[63]; e = op[62:52]; f = op[51:0];
        r = '0; z = 1'b0;
        if (e == 11'h7FF) begin
            r = '0; z = 1'b0;                          // R5
        end else if (e == 11'h000) begin
            r = '0; z = (f == '0) && !s;               // R6, R7
        end else begin
            ue = int'(e) - 1023;
            if (ue < 0 || ue >= 84) begin
                r = '0; z = 1'b0;                      // R4, R8
            end else begin
                big = {139'b0, 1'b1, f} << ue;
                ip  = big[191:52];
                inr = s ? (ip <= 140'h80000000) : (ip <= 140'h7FFFFFFF);
                r   = s ? (32'd0 - ip[31:0]) : ip[31:0];
                z   = inr && (big[51:0] == '0);
            end
        end
    endfunction

    task automatic check_out(input string tag, input logic [63:0] op,
                             input logic [31:0] er, input logic ez);
        logic [3:0] en;
        en = {1'b0, ez, 2'b00};   // R9: N, C, V expected zero
        n_chk++;
        if (out_vld !== 1'b1 || out_res !== er || out_nzcv !== en) begin
            n_fail++;
            $display("FAIL %s op=%h actual vld=%b res=%h nzcv=%b expected vld=1 res=%h nzcv=%b",
                     tag, op, out_vld, out_res, out_nzcv, er, en);
        end
    endtask

    task automatic run_one(input string tag, input logic [63:0] op);
        logic [31:0] er;
        logic        ez;
        @(negedge clk);
        in_vld = 1'b1;
        in_op  = op;
        @(negedge clk);
        in_vld = 1'b0;
        ref_conv(op, er, ez);
        check_out(tag, op, er, ez);
    endtask

    function automatic logic [63:0] rand_op();
        logic [10:0] e;
        logic [51:0] f;
        logic        s;
        s = 1'($urandom);
        f = {20'($urandom), $urandom};
        case ($urandom % 8)
            0:       e = 11'($urandom);
            1:       e = 11'd1023 + 11'($urandom % 90);
            default: e = 11'd1013 + 11'($urandom % 30);
        endcase
        if (($urandom % 4) == 0) f = f & ~((52'd1 << ($urandom % 52)) - 52'd1);
        return {s, e, f};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] prev;
        logic [31:0] er;
        logic        ez;
        logic [31:0] hr;
        logic [3:0]  hn;
        void'($urandom(32'd20240611));

        // R12: reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_vld !== 1'b0 || out_res !== '0 || out_nzcv !== '0) begin
            n_fail++;
            $display("FAIL R12 reset actual vld=%b res=%h nzcv=%b expected 0 0 0",
                     out_vld, out_res, out_nzcv);
        end
        rst = 1'b0;

        run_one("R1 3.7",           $realtobits(3.7));
        run_one("R1 -3.7",          $realtobits(-3.7));
        run_one("R1 123456.0",      $realtobits(123456.0));
        run_one("R4 0.5",           $realtobits(0.5));
        run_one("R4 -0.999",        $realtobits(-0.999));
        run_one("R4 1.5",           $realtobits(1.5));
        run_one("R3 max",           $realtobits(2147483647.0));
        run_one("R3 min",           $realtobits(-2147483648.0));
        run_one("R2 2^31",          $realtobits(2147483648.0));
        run_one("R2 -(2^31+1)",     $realtobits(-2147483649.0));
        run_one("R2 2^32+5",        $realtobits(4294967301.0));
        run_one("R2 -(2^32+5)",     $realtobits(-4294967301.0));
        run_one("R2 exp52",         64'h4330_0000_0000_0001);
        run_one("R2 exp83 lsb",     64'h4520_0000_0000_0001);
        run_one("R8 2^84",          64'h4530_0000_0000_0000);
        run_one("R8 maxfinite",     64'h7FEF_FFFF_FFFF_FFFF);
        run_one("R5 qnan",          64'h7FF8_0000_0000_0000);
        run_one("R5 +inf",          64'h7FF0_0000_0000_0000);
        run_one("R5 -inf",          64'hFFF0_0000_0000_0000);
        run_one("R6 +0",            64'h0000_0000_0000_0000);
        run_one("R6 -0",            64'h8000_0000_0000_0000);
        run_one("R7 min subnormal", 64'h0000_0000_0000_0001);
        run_one("R7 -max subnormal",64'h800F_FFFF_FFFF_FFFF);

        // R11: idle cycles with a changing operand leave outputs alone
        run_one("R1 -7.0",          $realtobits(-7.0));
        hr = out_res;
        hn = out_nzcv;
        for (int i = 0; i < 4; i++) begin
            in_op = rand_op();
            @(negedge clk);
            n_chk++;
            if (out_vld !== 1'b0 || out_res !== hr || out_nzcv !== hn) begin
                n_fail++;
                $display("FAIL R11 idle actual vld=%b res=%h nzcv=%b expected vld=0 res=%h nzcv=%b",
                         out_vld, out_res, out_nzcv, hr, hn);
            end
        end

        // R10 with R1/R2/R3: back-to-back random stream, one result per clock
        prev = '0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (i > 0) begin
                ref_conv(prev, er, ez);
                check_out("R10 stream R1/R2/R3", prev, er, ez);
            end
            prev   = rand_op();
            in_vld = 1'b1;
            in_op  = prev;
        end
        @(negedge clk);
        in_vld = 1'b0;
        ref_conv(prev, er, ez);
        check_out("R10 stream last", prev, er, ez);

        // R12: reset after a nonzero result
        run_one("R1 99.0", $realtobits(99.0));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        n_chk++;
        if (out_vld !== 1'b0 || out_res !== '0 || out_nzcv !== '0) begin
            n_fail++;
            $display("FAIL R12 mid reset actual vld=%b res=%h nzcv=%b expected 0 0 0",
                     out_vld, out_res, out_nzcv);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule